// File: doc/BRIEF.md
# Predicate Register File with Compare Write Modes

This block holds the one-bit qualifying flags of a predicated-execution datapath. There are 64 flags. Each cycle, up to two compare units report an outcome bit together with destination indices, and the file updates the flags they name. A set of registered read ports returns the flags that gate instructions in the next pipeline stage. Flag 0 is fixed, so unqualified operations always run.

There are three compare write modes. A plain compare writes its outcome to one flag and the inverse of its outcome to a second flag. A conjunctive compare can only clear its flag. A disjunctive compare can only set its flag. Several compares can therefore build an AND or OR of conditions in a single flag, even when they land in the same cycle.

The upper 48 flags form a rotating window for software-pipelined loops. A rotate pulse from the loop branch moves the logical-to-physical mapping by one place. A stage flag written at one logical index is then seen at the next index on the following iteration.

Top module: `pred_file`

## Requirements
- R1: After a synchronous active-high reset, every read port outputs 0. Every flag other than index 0 holds 0, and the rotation base is 0.
- R2: Reading index 0 always returns 1. A write aimed at index 0 has no effect.
- R3: A plain compare (mode 0) writes its outcome to `cmp_dst_a` and the inverse to `cmp_dst_b`. If both indices are equal, the inverse wins. Between ports, plain writes from the higher-numbered port win.
- R4: A conjunctive compare (mode 1) with outcome 0 clears `cmp_dst_a`. With outcome 1 it leaves that flag unchanged. It never uses `cmp_dst_b`.
- R5: A disjunctive compare (mode 2) with outcome 1 sets `cmp_dst_a`. With outcome 0 it leaves that flag unchanged. It never uses `cmp_dst_b`.
- R6: Writes that land on one flag in the same cycle resolve in a fixed order. Any clear from a conjunctive compare gives 0. Otherwise, any set from a disjunctive compare gives 1. Otherwise, the plain write applies. Mode 3, or an invalid port, changes nothing.
- R7: `rd_val[r]` is registered. It shows the flag named by `rd_idx[r]` one cycle later, taken from the state before that cycle's writes. A write becomes readable in the following cycle, with no same-cycle bypass.
- R8: Logical indices 0 to 15 map to themselves. Logical index L from 16 to 63 maps to physical index 16+((L-16+base) mod 48). A rotate pulse decrements the base modulo 48. The flag seen at logical L (16 to 62) is then seen at L+1, and logical 63 wraps to 16. Reads and writes in the pulse cycle use the old mapping.
- R9: After 48 rotate pulses the mapping returns to the identity, and every flag is again at its original logical index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rot_pulse | input | 1 | Rotate the upper window by one place |
| cmp_vld | input | NUM_WR | Compare port valid |
| cmp_mode | input | NUM_WR x 2 | 0 plain, 1 conjunctive, 2 disjunctive, 3 no-op |
| cmp_cond | input | NUM_WR | Compare outcome |
| cmp_dst_a | input | NUM_WR x 6 | Primary logical destination |
| cmp_dst_b | input | NUM_WR x 6 | Inverse destination (plain mode only) |
| rd_idx | input | NUM_RD x 6 | Logical read index |
| rd_val | output | NUM_RD | Registered flag value |

## Verification
A wrong flag bit stays hidden until some read port names its logical index. A read issued in cycle t shows it at t+1, so the bench keeps three read ports busy on varied indices every cycle. A wrong rotation base is different: it misplaces every upper-window read at once, on the first read after the faulty pulse. A wrong conflict resolution appears only when two compares meet on one flag, so the bench forces such collisions deliberately as well as at random.

// File: rtl/pf_pkg.sv
package pf_pkg;
  typedef enum logic [1:0] {
    CMP_PLAIN = 2'd0,
    CMP_CONJ  = 2'd1,
    CMP_DISJ  = 2'd2,
    CMP_NOP   = 2'd3
  } cmp_mode_e;
endpackage

// File: rtl/pf_map.sv
module pf_map #(
  parameter int NUM_PRED  = 64,
  parameter int ROT_FIRST = 16,
  localparam int IDX_W    = $clog2(NUM_PRED),
  localparam int ROT_SIZE = NUM_PRED - ROT_FIRST,
  localparam int RRB_W    = $clog2(ROT_SIZE)
) (
  input  logic [IDX_W-1:0] log_idx,
  input  logic [RRB_W-1:0] base,
  output logic [IDX_W-1:0] phys_idx
);
  localparam logic [IDX_W:0] FIRST_W = (IDX_W+1)'(ROT_FIRST);
  localparam logic [IDX_W:0] SIZE_W  = (IDX_W+1)'(ROT_SIZE);

  logic [IDX_W:0] offs, sum, wrapped;

  always_comb begin
    offs    = {1'b0, log_idx} - FIRST_W;
    sum     = offs + {{(IDX_W+1-RRB_W){1'b0}}, base};
    wrapped = (sum >= SIZE_W) ? (sum - SIZE_W) : sum;
    if ({1'b0, log_idx} < FIRST_W) phys_idx = log_idx;
    else                           phys_idx = IDX_W'(wrapped + FIRST_W);
  end
endmodule

// File: rtl/pf_rot_base.sv
module pf_rot_base #(
  parameter int ROT_SIZE = 48,
  localparam int RRB_W   = $clog2(ROT_SIZE)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rot_pulse,
  output logic [RRB_W-1:0] base
);
  localparam logic [RRB_W-1:0] LAST = RRB_W'(ROT_SIZE - 1);

  always_ff @(posedge clk) begin
    if (rst)            base <= '0;
    else if (rot_pulse) base <= (base == '0) ? LAST : base - 1'b1;
  end

  AST_BASE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rot_pulse |=> $stable(base)); // R8
  AST_BASE_RANGE: assert property (@(posedge clk) disable iff (rst)
    base <= LAST); // R9
  AST_BASE_WRAP: assert property (@(posedge clk) disable iff (rst)
    (rot_pulse && base == '0) |=> base == LAST); // R9
endmodule

// File: rtl/pf_update.sv
module pf_update
  import pf_pkg::*;
#(
  parameter int NUM_PRED = 64,
  parameter int NUM_WR   = 2,
  localparam int IDX_W   = $clog2(NUM_PRED)
) (
  input  logic [NUM_WR-1:0]            vld,
  input  logic [NUM_WR-1:0][1:0]       mode,
  input  logic [NUM_WR-1:0]            cond,
  input  logic [NUM_WR-1:0][IDX_W-1:0] pa,
  input  logic [NUM_WR-1:0][IDX_W-1:0] pb,
  input  logic [NUM_PRED-1:0]          cur,
  output logic [NUM_PRED-1:0]          nxt,
  output logic [NUM_PRED-1:0]          clr_hit,
  output logic [NUM_PRED-1:0]          set_hit
);
  for (genvar b = 0; b < NUM_PRED; b++) begin : g_bit
    logic v_plain, c_any, s_any;

    always_comb begin
      v_plain = cur[b];
      c_any   = 1'b0;
      s_any   = 1'b0;
      for (int p = 0; p < NUM_WR; p++) begin
        if (vld[p]) begin
          if (mode[p] == CMP_PLAIN) begin
            if (pa[p] == IDX_W'(b)) v_plain = cond[p];
            if (pb[p] == IDX_W'(b)) v_plain = ~cond[p];
          end
          if (mode[p] == CMP_CONJ && !cond[p] && pa[p] == IDX_W'(b)) c_any = 1'b1;
          if (mode[p] == CMP_DISJ &&  cond[p] && pa[p] == IDX_W'(b)) s_any = 1'b1;
        end
      end
    end

    if (b == 0) begin : g_fixed
      assign nxt[b] = 1'b0;
    end else begin : g_live
      assign nxt[b] = c_any ? 1'b0 : (s_any ? 1'b1 : v_plain);
    end
    assign clr_hit[b] = c_any;
    assign set_hit[b] = s_any;
  end
endmodule

// File: rtl/pf_read.sv
module pf_read #(
  parameter int NUM_PRED = 64,
  parameter int NUM_RD   = 3,
  localparam int IDX_W   = $clog2(NUM_PRED)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [NUM_RD-1:0][IDX_W-1:0] rd_phys,
  input  logic [NUM_PRED-1:0]          flags,
  output logic [NUM_RD-1:0]            rd_val
);
  for (genvar r = 0; r < NUM_RD; r++) begin : g_port
    always_ff @(posedge clk) begin
      if (rst)                 rd_val[r] <= 1'b0;
      else if (rd_phys[r] == '0) rd_val[r] <= 1'b1;
      else                     rd_val[r] <= flags[rd_phys[r]];
    end

    AST_P0_READS_ONE: assert property (@(posedge clk) disable iff (rst)
      (rd_phys[r] == '0) |=> rd_val[r]); // R2
  end
endmodule

// File: rtl/pred_file.sv
module pred_file
  import pf_pkg::*;
#(
  parameter int NUM_PRED  = 64,
  parameter int ROT_FIRST = 16,
  parameter int NUM_WR    = 2,
  parameter int NUM_RD    = 3,
  localparam int IDX_W    = $clog2(NUM_PRED),
  localparam int ROT_SIZE = NUM_PRED - ROT_FIRST,
  localparam int RRB_W    = $clog2(ROT_SIZE)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         rot_pulse,
  input  logic [NUM_WR-1:0]            cmp_vld,
  input  logic [NUM_WR-1:0][1:0]       cmp_mode,
  input  logic [NUM_WR-1:0]            cmp_cond,
  input  logic [NUM_WR-1:0][IDX_W-1:0] cmp_dst_a,
  input  logic [NUM_WR-1:0][IDX_W-1:0] cmp_dst_b,
  input  logic [NUM_RD-1:0][IDX_W-1:0] rd_idx,
  output logic [NUM_RD-1:0]            rd_val
);
  logic [RRB_W-1:0]             rot_base;
  logic [NUM_WR-1:0][IDX_W-1:0] wa_phys, wb_phys;
  logic [NUM_RD-1:0][IDX_W-1:0] rd_phys;
  logic [NUM_PRED-1:0]          pr_q, pr_d, clr_hit, set_hit;

  pf_rot_base #(.ROT_SIZE(ROT_SIZE)) u_base (
    .clk(clk), .rst(rst), .rot_pulse(rot_pulse), .base(rot_base)
  );

  for (genvar p = 0; p < NUM_WR; p++) begin : g_wmap
    pf_map #(.NUM_PRED(NUM_PRED), .ROT_FIRST(ROT_FIRST)) u_map_a (
      .log_idx(cmp_dst_a[p]), .base(rot_base), .phys_idx(wa_phys[p])
    );
    pf_map #(.NUM_PRED(NUM_PRED), .ROT_FIRST(ROT_FIRST)) u_map_b (
      .log_idx(cmp_dst_b[p]), .base(rot_base), .phys_idx(wb_phys[p])
    );

    AST_CONJ_CLEARS: assert property (@(posedge clk) disable iff (rst)
      (cmp_vld[p] && cmp_mode[p] == CMP_CONJ && !cmp_cond[p])
      |=> !pr_q[$past(wa_phys[p])]); // R4
    AST_DISJ_SETS: assert property (@(posedge clk) disable iff (rst)
      (cmp_vld[p] && cmp_mode[p] == CMP_DISJ && cmp_cond[p] &&
       wa_phys[p] != '0 && !clr_hit[wa_phys[p]])
      |=> pr_q[$past(wa_phys[p])]); // R5
  end

  AST_PLAIN_INVERSE: assert property (@(posedge clk) disable iff (rst)
    (cmp_vld[NUM_WR-1] && cmp_mode[NUM_WR-1] == CMP_PLAIN && wb_phys[NUM_WR-1] != '0 &&
     !clr_hit[wb_phys[NUM_WR-1]] && !set_hit[wb_phys[NUM_WR-1]])
    |=> pr_q[$past(wb_phys[NUM_WR-1])] == !$past(cmp_cond[NUM_WR-1])); // R3

  AST_P0_STORED_ZERO: assert property (@(posedge clk) disable iff (rst)
    cmp_vld[0] |=> !pr_q[0]); // R2

  for (genvar r = 0; r < NUM_RD; r++) begin : g_rmap
    pf_map #(.NUM_PRED(NUM_PRED), .ROT_FIRST(ROT_FIRST)) u_map_r (
      .log_idx(rd_idx[r]), .base(rot_base), .phys_idx(rd_phys[r])
    );
  end

  pf_update #(.NUM_PRED(NUM_PRED), .NUM_WR(NUM_WR)) u_upd (
    .vld(cmp_vld), .mode(cmp_mode), .cond(cmp_cond),
    .pa(wa_phys), .pb(wb_phys), .cur(pr_q),
    .nxt(pr_d), .clr_hit(clr_hit), .set_hit(set_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) pr_q <= '0;
    else     pr_q <= pr_d;
  end

  pf_read #(.NUM_PRED(NUM_PRED), .NUM_RD(NUM_RD)) u_rd (
    .clk(clk), .rst(rst), .rd_phys(rd_phys), .flags(pr_q), .rd_val(rd_val)
  );
endmodule

// File: tb/test_pred_file.sv
`timescale 1ns/1ps
module test_pred_file;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rot_pulse = 1'b0;
  logic [1:0]      cmp_vld = '0;
  logic [1:0][1:0] cmp_mode = '0;
  logic [1:0]      cmp_cond = '0;
  logic [1:0][5:0] cmp_dst_a = '0;
  logic [1:0][5:0] cmp_dst_b = '0;
  logic [2:0][5:0] rd_idx = '0;
  logic [2:0]      rd_val;

  int tests = 0;
  int fails = 0;
  bit [63:0] m;
  int rrb_m;
  bit [2:0] exp_rd;

  always #10 clk = ~clk;

  pred_file i_pred_file (
    .clk(clk), .rst(rst), .rot_pulse(rot_pulse),
    .cmp_vld(cmp_vld), .cmp_mode(cmp_mode), .cmp_cond(cmp_cond),
    .cmp_dst_a(cmp_dst_a), .cmp_dst_b(cmp_dst_b),
    .rd_idx(rd_idx), .rd_val(rd_val)
  );

  function automatic int phys(int l);
    if (l < 16) return l;
    return 16 + ((l - 16 + rrb_m) % 48);
  endfunction

  task automatic model_step();
    bit [63:0] nm;
    for (int r = 0; r < 3; r++)
      exp_rd[r] = (rd_idx[r] == 0) ? 1'b1 : m[phys(int'(rd_idx[r]))];
    nm = m;
    for (int p = 0; p < 2; p++)
      if (cmp_vld[p] && cmp_mode[p] == 2'd0) begin
        nm[phys(int'(cmp_dst_a[p]))] = cmp_cond[p];
        nm[phys(int'(cmp_dst_b[p]))] = !cmp_cond[p];
      end
    for (int p = 0; p < 2; p++)
      if (cmp_vld[p] && cmp_mode[p] == 2'd2 && cmp_cond[p]) nm[phys(int'(cmp_dst_a[p]))] = 1'b1;
    for (int p = 0; p < 2; p++)
      if (cmp_vld[p] && cmp_mode[p] == 2'd1 && !cmp_cond[p]) nm[phys(int'(cmp_dst_a[p]))] = 1'b0;
    nm[0] = 1'b0;
    m = nm;
    if (rot_pulse) rrb_m = (rrb_m + 47) % 48;
  endtask

  task automatic step(input string tag);
    @(posedge clk);
    model_step();
    @(negedge clk);
    for (int r = 0; r < 3; r++) begin
      tests++;
      if (rd_val[r] !== exp_rd[r]) begin
        fails++;
        $display("FAIL %s port %0d idx %0d: got %0b expected %0b", tag, r, rd_idx[r], rd_val[r], exp_rd[r]);
      end
    end
  endtask

  task automatic quiet();
    cmp_vld = '0; cmp_mode = '0; cmp_cond = '0; rot_pulse = 1'b0;
    cmp_dst_a = '0; cmp_dst_b = '0;
  endtask

  task automatic cmp(input int p, input int md, input bit c, input int a, input int b);
    cmp_vld[p] = 1'b1; cmp_mode[p] = 2'(md); cmp_cond[p] = c;
    cmp_dst_a[p] = 6'(a); cmp_dst_b[p] = 6'(b);
  endtask

  task automatic rd(input int a, input int b, input int c);
    rd_idx[0] = 6'(a); rd_idx[1] = 6'(b); rd_idx[2] = 6'(c);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    m = '0; rrb_m = 0; exp_rd = '0;
    repeat (3) @(negedge clk);
    tests++;
    if (rd_val !== 3'b000) begin
      fails++;
      $display("FAIL R1 reset: got %b expected 000", rd_val);
    end
    rst = 1'b0;
    // R1: reset contents
    rd(0, 5, 63); step("R1");
    // R2: writes aimed at index 0 are dropped
    cmp(0, 0, 1'b1, 0, 3); cmp(1, 0, 1'b0, 7, 0); rd(0, 0, 0); step("R2");
    quiet(); rd(0, 3, 7); step("R2");
    // R3: plain pair, inverse wins, higher port wins
    cmp(0, 0, 1'b1, 4, 5); cmp(1, 0, 1'b1, 9, 4); step("R3");
    quiet(); rd(4, 5, 9); step("R3");
    cmp(0, 0, 1'b1, 11, 11); step("R3");
    quiet(); rd(11, 4, 9); step("R3");
    // R4: conjunctive compare
    cmp(0, 0, 1'b1, 12, 13); cmp(1, 0, 1'b1, 14, 15); step("R4");
    quiet(); cmp(0, 1, 1'b1, 12, 14); cmp(1, 1, 1'b0, 14, 12); step("R4");
    quiet(); rd(12, 14, 13); step("R4");
    // R5: disjunctive compare
    cmp(0, 2, 1'b0, 13, 12); cmp(1, 2, 1'b1, 15, 12); step("R5");
    quiet(); rd(13, 15, 12); step("R5");
    // R6: same-cycle collisions and no-op mode
    cmp(0, 1, 1'b0, 20, 0); cmp(1, 2, 1'b1, 20, 0); step("R6");
    quiet(); cmp(0, 0, 1'b0, 21, 22); cmp(1, 2, 1'b1, 21, 0); step("R6");
    quiet(); cmp(0, 3, 1'b1, 9, 9); cmp(1, 3, 1'b0, 22, 22); rd(20, 21, 22); step("R6");
    quiet(); rd(9, 22, 20); step("R6");
    // R7: read in the write cycle sees old value
    cmp(0, 0, 1'b1, 10, 2); rd(10, 2, 10); step("R7");
    quiet(); rd(10, 2, 10); step("R7");
    // R8: rotation moves upper flags by one
    cmp(0, 0, 1'b1, 16, 63); rd(16, 17, 63); step("R8");
    quiet(); rot_pulse = 1'b1; rd(16, 17, 63); step("R8");
    quiet(); rd(16, 17, 63); step("R8");
    rot_pulse = 1'b1; cmp(0, 2, 1'b1, 40, 0); rd(40, 41, 18); step("R8");
    quiet(); rd(40, 41, 18); step("R8");
    // R9: full turn
    for (int k = 0; k < 46; k++) begin
      rot_pulse = 1'b1; rd(16 + (k % 48), 63, 17); step("R9");
    end
    quiet(); rd(16, 17, 63); step("R9");
    rd(40, 41, 18); step("R9");
    // mixed random traffic with rotation
    for (int k = 0; k < 600; k++) begin
      for (int p = 0; p < 2; p++) begin
        cmp_vld[p]   = 1'($urandom_range(0, 3) != 0);
        cmp_mode[p]  = 2'($urandom_range(0, 3));
        cmp_cond[p]  = 1'($urandom_range(0, 1));
        cmp_dst_a[p] = 6'($urandom_range(0, 63));
        cmp_dst_b[p] = 6'($urandom_range(0, 63));
      end
      if ($urandom_range(0, 2) == 0) cmp_dst_a[1] = cmp_dst_a[0];
      rot_pulse = 1'($urandom_range(0, 7) == 0);
      rd(int'($urandom_range(0, 63)), int'($urandom_range(0, 63)), int'(cmp_dst_a[0]));
      step("R6");
    end
    quiet(); step("R6");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule